// File: doc/BRIEF.md
# SPI Control Transaction Register Engine

This block is the device-side engine for register access over an SPI link. The host lowers chip select and shifts in a 32-bit command word. The engine decodes that word into a type flag, a direction, an address-hold mode, a register-map select, a 16-bit start address and a burst length, and it checks the word's odd parity. A valid header starts a burst of up to 128 register reads or writes on a simple internal register bus. In the word after the header, the engine echoes the header back to the host with its header-fault bit and parity regenerated.

The SPI clock is assumed to be sampled already: each serial bit arrives as a one-cycle `bit_en` strobe with `mosi` valid. `miso` is a registered output that the host reads before it issues the next strobe. Raising chip select at any point ends the transaction. The next selection begins with a fresh header.

Top module: `spi_ctl_engine`

## Requirements
- R1: Words are 32 bits and shift most significant bit first, one bit per `bit_en` cycle. The header has this layout: bit 31 type (0 = register, 1 = data frame), bit 30 header fault, bit 29 direction (1 = write, 0 = read), bit 28 address hold, bits 27:24 map select, bits 23:8 start address, bits 7:1 length minus one, bit 0 parity. While the header shifts in, `miso` carries zeros.
- R2: A header with bit 31 set causes no register access, and `miso` stays zero for the rest of that selection.
- R3: A register header is valid only when all 32 bits hold an odd number of ones. An invalid header causes no register access, and its echo has bit 30 set.
- R4: Word 1 carries the echo. The echo is the received header with bit 30 replaced by the fault flag (0 when the header is valid) and bit 0 recomputed so the echo has odd parity. The host's own bit 30 plays no part in the fault decision.
- R5: For a write, words 1 to length+1 from the host are the data. Each data word produces a one-cycle `reg_wr` pulse that carries the map select, the address and that word. `miso` is zero after the echo.
- R6: For a read, each register gets one `reg_rd` pulse. Words 2 to length+2 return the data in order, and `miso` is zero after that. Each read must see `reg_rvalid` before the next word completes.
- R7: A valid header makes exactly length+1 accesses (1 to 128). Words past the burst cause no access.
- R8: With bit 28 clear, the address rises by one after each access and wraps modulo 2^16. With bit 28 set, every access in the burst uses the start address.
- R9: Raising `cs_n` aborts the burst. No access follows, a partly shifted word is discarded, `miso` goes to 0, and the next selection is decoded as a new header.
- R10: After reset, `miso`, `reg_wr` and `reg_rd` are 0.
- R11: `reg_rd` and `reg_wr` never assert together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| mosi | input | 1 | Serial data from host, valid with `bit_en` |
| miso | output | 1 | Serial data to host, registered |
| reg_map | output | 4 | Register map select |
| reg_addr | output | 16 | Register address |
| reg_wr | output | 1 | Write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rd | output | 1 | Read strobe |
| reg_rdata | input | 32 | Read data |
| reg_rvalid | input | 1 | Read data valid |

## Verification
During a read burst, two things happen at every word boundary. The engine loads the returned data for the previous register into the output shifter, and it issues the read strobe and address step for the next register. The echo load and the first read strobe also share the boundary that closes the header. The bench sweeps read and write bursts of several lengths, with and without address hold, starting both in mid-range and just below the address wrap. Its register model answers each read after a latency of one to four cycles and tags each answer with its map, address and order. Every returned word is therefore judged against the arithmetically predicted address sequence, so a skipped, repeated or late access shows up as a mismatch.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int WORD_W = 32;
  localparam int MAP_W  = 4;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 7;
  localparam int CNT_W  = LEN_W + 1;
  localparam int FAULT_BIT = 30;

  typedef struct packed {
    logic              is_data;
    logic              fault;
    logic              write;
    logic              hold;
    logic [MAP_W-1:0]  map;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              par;
  } cmd_hdr_t;

  typedef enum logic [1:0] {ST_HDR, ST_WR, ST_RD, ST_SKIP} burst_st_t;

  function automatic logic odd_fill(input logic [WORD_W-2:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/spi_ctl_shifter.sv
module spi_ctl_shifter
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              bit_en,
  input  logic              mosi,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  output logic              miso,
  output logic              word_done,
  output logic [WORD_W-1:0] word_in
);
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  logic [BC_W-1:0]   bcnt;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      rx_sh     <= '0;
      tx_sh     <= '0;
      bcnt      <= '0;
      word_done <= 1'b0;
      word_in   <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_en) begin
        rx_sh <= {rx_sh[WORD_W-2:0], mosi};
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        if (bcnt == LAST_BIT) begin
          bcnt      <= '0;
          word_done <= 1'b1;
          word_in   <= {rx_sh[WORD_W-2:0], mosi};
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
      if (load_en) tx_sh <= load_word;
    end
  end

  assign miso = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_ctl_hdr_chk.sv
module spi_ctl_hdr_chk
  import spi_ctl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_hdr_t          hdr,
  output logic              par_ok,
  output logic [WORD_W-1:0] echo
);
  logic [WORD_W-1:0] body;

  always_comb begin
    hdr    = cmd_hdr_t'(word);
    par_ok = ^word;
    body   = word;
    body[FAULT_BIT] = ~par_ok;
    body[0] = odd_fill(body[WORD_W-1:1]);
    echo   = body;
  end
endmodule

// File: rtl/spi_ctl_burst.sv
module spi_ctl_burst
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_in,
  input  cmd_hdr_t          hdr,
  input  logic              par_ok,
  input  logic [WORD_W-1:0] echo,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_rvalid,
  output logic              load_en,
  output logic [WORD_W-1:0] load_word,
  output logic [MAP_W-1:0]  reg_map,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_rd
);
  burst_st_t         state;
  logic [ADDR_W-1:0] cur_addr;
  logic              hold;
  logic [CNT_W-1:0]  left_acc;
  logic [CNT_W-1:0]  left_tx;
  logic [WORD_W-1:0] rd_buf;
  logic [CNT_W-1:0]  burst_n;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic h);
    return h ? a : a + 1'b1;
  endfunction

  assign burst_n = CNT_W'(hdr.len) + 1'b1;

  always_comb begin
    load_en   = word_done && !cs_n;
    load_word = '0;
    case (state)
      ST_HDR:  load_word = hdr.is_data ? '0 : echo;
      ST_RD:   load_word = rd_buf;
      default: load_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      state     <= ST_HDR;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_map   <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      cur_addr  <= '0;
      hold      <= 1'b0;
      left_acc  <= '0;
      left_tx   <= '0;
      rd_buf    <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_rvalid) rd_buf <= reg_rdata;
      if (word_done) begin
        case (state)
          ST_HDR: begin
            if (hdr.is_data || !par_ok) begin
              state <= ST_SKIP;
            end else begin
              reg_map <= hdr.map;
              hold    <= hdr.hold;
              if (hdr.write) begin
                cur_addr <= hdr.addr;
                left_acc <= burst_n;
                state    <= ST_WR;
              end else begin
                reg_rd   <= 1'b1;
                reg_addr <= hdr.addr;
                cur_addr <= step(hdr.addr, hdr.hold);
                left_acc <= CNT_W'(hdr.len);
                left_tx  <= burst_n;
                state    <= ST_RD;
              end
            end
          end
          ST_WR: begin
            reg_wr    <= 1'b1;
            reg_wdata <= word_in;
            reg_addr  <= cur_addr;
            cur_addr  <= step(cur_addr, hold);
            left_acc  <= left_acc - 1'b1;
            if (left_acc == CNT_W'(1)) state <= ST_SKIP;
          end
          ST_RD: begin
            left_tx <= left_tx - 1'b1;
            if (left_tx == CNT_W'(1)) state <= ST_SKIP;
            if (left_acc != '0) begin
              reg_rd   <= 1'b1;
              reg_addr <= cur_addr;
              cur_addr <= step(cur_addr, hold);
              left_acc <= left_acc - 1'b1;
            end
          end
          default: state <= ST_SKIP;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              bit_en,
  input  logic              mosi,
  output logic              miso,
  output logic [MAP_W-1:0]  reg_map,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_rvalid
);
  logic              word_done;
  logic [WORD_W-1:0] word_in;
  logic              load_en;
  logic [WORD_W-1:0] load_word;
  cmd_hdr_t          hdr;
  logic              par_ok;
  logic [WORD_W-1:0] echo;

  spi_ctl_shifter u_shift (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_en(bit_en), .mosi(mosi),
    .load_en(load_en), .load_word(load_word), .miso(miso),
    .word_done(word_done), .word_in(word_in)
  );

  spi_ctl_hdr_chk u_hdr (
    .word(word_in), .hdr(hdr), .par_ok(par_ok), .echo(echo)
  );

  spi_ctl_burst u_burst (
    .clk(clk), .rst(rst), .cs_n(cs_n), .word_done(word_done),
    .word_in(word_in), .hdr(hdr), .par_ok(par_ok), .echo(echo),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .load_en(load_en), .load_word(load_word), .reg_map(reg_map),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd)
  );
endmodule

// File: rtl/spi_ctl_engine_chk.sv
module spi_ctl_engine_chk
  import spi_ctl_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic miso,
  input logic reg_wr,
  input logic reg_rd
);
  localparam int MAX_ACC = 1 << LEN_W;
  logic [CNT_W:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst || cs_n) acc_cnt <= '0;
    else if ((reg_wr || reg_rd) && acc_cnt != '1) acc_cnt <= acc_cnt + 1'b1;
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(reg_rd && reg_wr)); // R11
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) (reg_rd || reg_wr) |=> !(reg_rd || reg_wr)); // R11
  AST_ACC_LIMIT: assert property (@(posedge clk) disable iff (rst) acc_cnt <= (CNT_W+1)'(MAX_ACC)); // R7
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst) cs_n |=> !(reg_rd || reg_wr)); // R9
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst) cs_n |=> !miso); // R9
endmodule

bind spi_ctl_engine spi_ctl_engine_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .miso(miso), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/tb_spi_ctl_engine.sv
`timescale 1ns/1ps
module tb_spi_ctl_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        bit_en = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic [3:0]  reg_map;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        reg_rd;
  logic [31:0] reg_rdata = '0;
  logic        reg_rvalid = 1'b0;

  int nchk = 0;
  int nfail = 0;

  logic [31:0] rxw [0:139];
  logic [31:0] log_data [0:1023];
  logic [15:0] log_addr [0:1023];
  logic [3:0]  log_map  [0:1023];
  logic        log_wr   [0:1023];
  int log_n = 0;
  int rd_seq = 0;
  int pend = 0;
  logic [31:0] pend_data = '0;

  always #2.5 clk = ~clk;

  spi_ctl_engine dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_en(bit_en), .mosi(mosi),
    .miso(miso), .reg_map(reg_map), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  // register model: logs accesses, answers reads after 1..4 cycles
  always @(negedge clk) begin
    reg_rvalid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        reg_rvalid = 1'b1;
        reg_rdata  = pend_data;
      end
    end
    if (reg_wr || reg_rd) begin
      log_data[log_n % 1024] = reg_wdata;
      log_addr[log_n % 1024] = reg_addr;
      log_map[log_n % 1024]  = reg_map;
      log_wr[log_n % 1024]   = reg_wr;
      log_n = log_n + 1;
    end
    if (reg_rd) begin
      pend_data = {4'hA, reg_map, reg_addr, rd_seq[7:0]};
      pend = 1 + (rd_seq % 4);
      rd_seq = rd_seq + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic dnc, input logic flt, input logic wr,
                                     input logic hld, input logic [3:0] map,
                                     input logic [15:0] addr, input logic [6:0] len,
                                     input logic bad);
    logic [30:0] up;
    up = {dnc, flt, wr, hld, map, addr, len};
    return {up, (~^up) ^ bad};
  endfunction

  function automatic logic [31:0] wdat(input logic [31:0] hdr, input int w);
    return {hdr[23:8] ^ 16'h5A5A, 8'h3C, 8'(w)};
  endfunction

  task automatic xfer(input logic [31:0] tx, input int nb, output logic [31:0] rx);
    rx = '0;
    for (int i = 31; i >= 32 - nb; i--) begin
      mosi = tx[i];
      rx[i] = miso;
      bit_en = 1'b1;
      @(posedge clk); #1;
      bit_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
    end
  endtask

  task automatic do_txn(input logic [31:0] hdr, input int nw, input int partial);
    logic [31:0] r;
    cs_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    for (int w = 0; w < nw; w++) begin
      xfer((w == 0) ? hdr : wdat(hdr, w), 32, r);
      rxw[w] = r;
    end
    if (partial > 0) xfer(wdat(hdr, nw), partial, r);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 miso idle after deselect", {31'd0, miso}, 32'd0);
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic verify(input logic [31:0] hdr, input int nw, input int bl, input int bs,
                        input int exp_acc);
    logic [31:0] ec;
    logic [15:0] ea;
    logic good;
    int k;
    good = !hdr[31] && (^hdr);
    ec = hdr;
    ec[30] = ~(^hdr);
    ec[0] = ~^ec[31:1];
    check("R1 miso zero during header", rxw[0], 32'd0);
    if (hdr[31]) check("R2 no echo for data header", rxw[1], 32'd0);
    else if (!good) check("R3 bad header echo", rxw[1], ec);
    else check("R4 echo header", rxw[1], ec);
    check("R7 access count", 32'(log_n - bl), 32'(exp_acc));
    for (int j = 0; j < exp_acc; j++) begin
      k = (bl + j) % 1024;
      ea = hdr[28] ? hdr[23:8] : hdr[23:8] + 16'(j);
      check("R8 access address", {16'd0, log_addr[k]}, {16'd0, ea});
      check("R5 R6 access map", {28'd0, log_map[k]}, {28'd0, hdr[27:24]});
      check("R5 R6 access kind", {31'd0, log_wr[k]}, {31'd0, hdr[29]});
      if (hdr[29]) check("R5 write data", log_data[k], wdat(hdr, j + 1));
    end
    for (int w = 2; w < nw; w++) begin
      k = w - 2;
      ea = hdr[28] ? hdr[23:8] : hdr[23:8] + 16'(k);
      if (good && !hdr[29] && k < exp_acc)
        check("R6 read data word", rxw[w], {4'hA, hdr[27:24], ea, 8'(bs + k)});
      else if (!good) check("R2 R3 miso quiet", rxw[w], 32'd0);
      else check("R5 R6 miso zero after burst", rxw[w], 32'd0);
    end
  endtask

  task automatic run(input logic [31:0] hdr, input int nw, input int exp_acc);
    int bl;
    int bs;
    bl = log_n;
    bs = rd_seq;
    do_txn(hdr, nw, 0);
    verify(hdr, nw, bl, bs, exp_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] h;
    int lens [4] = '{0, 1, 3, 6};
    int idx;
    int bl;
    int bs;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk); #1;
    check("R10 reset miso", {31'd0, miso}, 32'd0);
    check("R10 reset strobes", {30'd0, reg_wr, reg_rd}, 32'd0);

    // sweep direction, hold, length and start address (incl. wrap)
    idx = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int hl = 0; hl < 2; hl++)
        for (int li = 0; li < 4; li++) begin
          h = mk(1'b0, 1'b0, wr[0], hl[0], 4'(idx + 1),
                 idx[0] ? 16'hFFFE : 16'(16'h0120 + lens[li]), 7'(lens[li]), 1'b0);
          run(h, lens[li] + 3, lens[li] + 1);
          idx++;
        end

    // host fault bit set with good parity is ignored
    run(mk(1'b0, 1'b1, 1'b0, 1'b0, 4'h7, 16'h3000, 7'd2, 1'b0), 5, 3);
    run(mk(1'b0, 1'b1, 1'b1, 1'b0, 4'h8, 16'h4000, 7'd1, 1'b0), 4, 2);
    // bad parity: fault echo, no accesses
    run(mk(1'b0, 1'b0, 1'b0, 1'b0, 4'h2, 16'h1111, 7'd2, 1'b1), 5, 0);
    run(mk(1'b0, 1'b1, 1'b1, 1'b1, 4'h3, 16'h2222, 7'd1, 1'b1), 4, 0);
    // data-frame header: ignored
    run(mk(1'b1, 1'b0, 1'b1, 1'b0, 4'h4, 16'h5555, 7'd1, 1'b0), 4, 0);
    run(mk(1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 16'h6666, 7'd0, 1'b1), 3, 0);

    // abort: write of 6 cut after 2 data words plus part of a third
    h = mk(1'b0, 1'b0, 1'b1, 1'b0, 4'h9, 16'h0700, 7'd5, 1'b0);
    bl = log_n;
    bs = rd_seq;
    do_txn(h, 3, 10);
    verify(h, 3, bl, bs, 2);
    // R9: next selection is a fresh header
    run(mk(1'b0, 1'b0, 1'b0, 1'b0, 4'hB, 16'h0900, 7'd1, 1'b0), 4, 2);

    // maximum burst, address held (FIFO style) and incrementing across wrap
    run(mk(1'b0, 1'b0, 1'b0, 1'b1, 4'hC, 16'h00F0, 7'd127, 1'b0), 130, 128);
    run(mk(1'b0, 1'b0, 1'b1, 1'b0, 4'hD, 16'hFFC0, 7'd127, 1'b0), 130, 128);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule